// File: doc/BRIEF.md
# Collapsible Pipeline Stage Controller

This block governs one intermediate holding register between two halves of a request/acknowledge pipeline. In its active mode the register behaves as a normal stage. It captures each incoming packet and acknowledges it locally, so the upstream half can move on while the downstream half is still busy. In its merged mode the register stays transparent. The request passes straight through to the downstream side, the downstream acknowledge is relayed back upstream, and the register enable never fires. In this mode the two neighbouring stages act as one.

Every packet carries a 2-bit control tag. The tag can switch the stage to the other mode, and the switch applies to the packet that carries the tag. A switch happens only on a completed handshake, so no packet is lost or duplicated. A capture counter lets a system confirm that a merged stage spends no enable switching.

Top module: `collapsible_stage_ctrl`

## Requirements
- R1: After reset the stage is active (`merged_o`=0) and empty. `dn_req`=0, `up_ack`=1 and `load_cnt`=0.
- R2: An active, empty stage acknowledges a packet with tag 00 whatever `dn_ack` is. The packet appears on `dn_data` with `dn_req`=1 on the next cycle.
- R3: An active, full stage that sees `dn_ack`=0 drives `up_ack`=0 and holds `dn_req` and `dn_data` unchanged.
- R4: An active, full stage that sees `dn_ack`=1 accepts a new packet in the same cycle. The new packet is presented downstream on the next cycle, which gives one packet per cycle.
- R5: Tag 01 (merge) on an active stage passes the packet through in the same cycle. This needs the register empty and `dn_ack`=1. From the next cycle `merged_o`=1.
- R6: While merged, for packets that do not restore, `dn_req` equals `up_req`, `dn_data` equals `up_data` and `up_ack` equals `dn_ack` within the same cycle.
- R7: Tag 10 (split) on a merged stage is captured and acknowledged even while `dn_ack`=0. On the next cycle `merged_o`=0 and the packet is presented downstream.
- R8: Tag 11 is treated as keep. A tag that names the current mode is also treated as keep: 10 while active, 01 while merged.
- R9: A merge-tagged packet that arrives while the register is full is not acknowledged until the held packet has left.
- R10: `load_cnt` rises by one for each capture into the register. It does not change while merged, except for the capture of a split packet.
- R11: Over any mix of tags and downstream stalls, packets leave in the order they entered, each exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| up_req | input | 1 | Upstream packet request |
| up_data | input | DATA_W | Upstream packet payload |
| up_tag | input | 2 | Control tag: 00/11 keep, 01 merge, 10 split |
| up_ack | output | 1 | Acknowledge to upstream |
| dn_req | output | 1 | Request to downstream |
| dn_data | output | DATA_W | Payload to downstream |
| dn_tag | output | 2 | Tag forwarded with the payload |
| dn_ack | input | 1 | Acknowledge from downstream |
| merged_o | output | 1 | 1 while the register is bypassed |
| load_cnt | output | CNT_W | Count of register captures |

## Verification
The assertions check four rules on every cycle: a stalled full stage holds its output, a merged stage relays the request and the acknowledge, a merge is never accepted over a held packet, and a split packet is always acknowledged and restores the stage. The counter freeze while merged is also checked every cycle. Only the bench scenarios can show that packets stay in order without loss across many mode switches. They also show that keep-equivalent tags leave the mode alone and that throughput reaches one packet per cycle when active.

// File: rtl/cstage_pkg.sv
package cstage_pkg;
    typedef enum logic [1:0] {
        TAG_KEEP  = 2'b00,
        TAG_MERGE = 2'b01,
        TAG_SPLIT = 2'b10,
        TAG_HOLD  = 2'b11
    } stage_tag_e;

    typedef struct packed {
        logic full;
        logic merged;
    } stage_ctrl_s;
endpackage

// File: rtl/stage_tag_decode.sv
module stage_tag_decode
    import cstage_pkg::*;
(
    input  logic [1:0] tag,
    input  logic       merged,
    output logic       want_merge,
    output logic       want_split
);
    // A tag naming the current mode is reduced to keep here
    always_comb begin
        want_merge = (tag == TAG_MERGE) && !merged;
        want_split = (tag == TAG_SPLIT) &&  merged;
    end
endmodule

// File: rtl/stage_hold_reg.sv
module stage_hold_reg #(
    parameter int W = 18
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] q_d, q_q;

    always_comb q_d = en ? d : q_q;

    always_ff @(posedge clk) begin
        if (!rst_n) q_q <= '0;
        else        q_q <= q_d;
    end

    assign q = q_q;
endmodule

// File: rtl/stage_load_counter.sv
module stage_load_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bump,
    output logic [CNT_W-1:0] cnt
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb cnt_d = bump ? cnt_q + 1'b1 : cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;
endmodule

// File: rtl/collapsible_stage_ctrl.sv
module collapsible_stage_ctrl
    import cstage_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              up_req,
    input  logic [DATA_W-1:0] up_data,
    input  logic [1:0]        up_tag,
    output logic              up_ack,
    output logic              dn_req,
    output logic [DATA_W-1:0] dn_data,
    output logic [1:0]        dn_tag,
    input  logic              dn_ack,
    output logic              merged_o,
    output logic [CNT_W-1:0]  load_cnt
);
    localparam int PKT_W = DATA_W + 2;

    stage_ctrl_s ctrl_d, ctrl_q;
    logic        want_merge, want_split;
    logic        pass_path, accept, load_en;
    logic [PKT_W-1:0] held_pkt;

    stage_tag_decode u_dec (
        .tag        (up_tag),
        .merged     (ctrl_q.merged),
        .want_merge (want_merge),
        .want_split (want_split)
    );

    always_comb begin
        // Packet goes straight through instead of into the register
        pass_path = up_req && (ctrl_q.merged ? !want_split
                                             : (want_merge && !ctrl_q.full));
        if (ctrl_q.merged)
            up_ack = want_split ? 1'b1 : dn_ack;
        else if (want_merge)
            up_ack = !ctrl_q.full && dn_ack;
        else
            up_ack = !ctrl_q.full || dn_ack;

        accept  = up_req && up_ack;
        load_en = accept && !pass_path;

        dn_req  = ctrl_q.full || pass_path;
        dn_data = ctrl_q.full ? held_pkt[DATA_W-1:0] : up_data;
        dn_tag  = ctrl_q.full ? held_pkt[PKT_W-1:DATA_W] : up_tag;

        ctrl_d = ctrl_q;
        if (load_en)
            ctrl_d.full = 1'b1;
        else if (ctrl_q.full && dn_ack)
            ctrl_d.full = 1'b0;
        if (accept && !ctrl_q.merged && want_merge)
            ctrl_d.merged = 1'b1;
        else if (accept && ctrl_q.merged && want_split)
            ctrl_d.merged = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_d;
    end

    stage_hold_reg #(.W(PKT_W)) u_hold (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (load_en),
        .d     ({up_tag, up_data}),
        .q     (held_pkt)
    );

    stage_load_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .bump  (load_en),
        .cnt   (load_cnt)
    );

    assign merged_o = ctrl_q.merged;

    a_r3_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_req && !dn_ack && !merged_o && !(up_req && up_tag == 2'b01))
        |=> (dn_req && $stable(dn_data)));

    a_r6_merged_relay: assert property (@(posedge clk) disable iff (!rst_n)
        (merged_o && !(up_req && up_tag == 2'b10))
        |-> ((up_ack == dn_ack) && (dn_req == up_req)));

    a_r7_split_restores: assert property (@(posedge clk) disable iff (!rst_n)
        (merged_o && up_req && up_tag == 2'b10)
        |-> up_ack ##1 (!merged_o && dn_req));

    a_r9_merge_waits: assert property (@(posedge clk) disable iff (!rst_n)
        (!merged_o && ctrl_q.full && up_req && up_tag == 2'b01) |-> !up_ack);

    a_r10_no_loads_merged: assert property (@(posedge clk) disable iff (!rst_n)
        (merged_o && !(up_req && up_tag == 2'b10)) |=> $stable(load_cnt));
endmodule

// File: tb/tb_collapsible_stage_ctrl.sv
module tb_collapsible_stage_ctrl;
    localparam int DW = 16;
    localparam int CW = 16;

    logic          clk = 0;
    logic          rst_n = 0;
    logic          up_req = 0;
    logic [DW-1:0] up_data = '0;
    logic [1:0]    up_tag = 2'b00;
    logic          up_ack, dn_req, merged_o;
    logic [DW-1:0] dn_data;
    logic [1:0]    dn_tag;
    logic          dn_ack = 0;
    logic [CW-1:0] load_cnt;

    int tests = 0;
    int fails = 0;

    always #5 clk = ~clk;

    collapsible_stage_ctrl #(.DATA_W(DW), .CNT_W(CW)) dut (
        .clk(clk), .rst_n(rst_n), .up_req(up_req), .up_data(up_data),
        .up_tag(up_tag), .up_ack(up_ack), .dn_req(dn_req), .dn_data(dn_data),
        .dn_tag(dn_tag), .dn_ack(dn_ack), .merged_o(merged_o), .load_cnt(load_cnt)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic drive(input logic r, input logic [DW-1:0] d, input logic [1:0] t, input logic a);
        up_req = r; up_data = d; up_tag = t; dn_ack = a;
        #1;
    endtask

    task automatic t_reset();
        chk("R1 merged", merged_o, 0);
        chk("R1 dn_req", dn_req, 0);
        chk("R1 up_ack", up_ack, 1);
        chk("R1 load_cnt", load_cnt, 0);
    endtask

    task automatic t_active();
        drive(1, 16'hA001, 2'b00, 0);
        chk("R2 ack while empty", up_ack, 1);
        step();
        drive(0, 0, 2'b00, 0);
        chk("R2 dn_req", dn_req, 1);
        chk("R2 dn_data", dn_data, 16'hA001);
        chk("R10 one load", load_cnt, 1);
        drive(1, 16'hB002, 2'b00, 0);
        chk("R3 no ack when full", up_ack, 0);
        step();
        drive(1, 16'hB002, 2'b00, 0);
        chk("R3 data held", dn_data, 16'hA001);
        drive(1, 16'hB002, 2'b00, 1);
        chk("R4 ack on drain", up_ack, 1);
        step();
        drive(0, 0, 2'b00, 1);
        chk("R4 next packet", dn_data, 16'hB002);
        chk("R4 dn_req", dn_req, 1);
        step();
        drive(0, 0, 2'b00, 0);
        chk("R4 drained", dn_req, 0);
    endtask

    task automatic t_merge();
        drive(1, 16'hC003, 2'b00, 0);
        step();
        drive(1, 16'hD004, 2'b01, 0);
        chk("R9 merge blocked stall", up_ack, 0);
        drive(1, 16'hD004, 2'b01, 1);
        chk("R9 merge blocked full", up_ack, 0);
        chk("R9 held out", dn_data, 16'hC003);
        step();
        drive(1, 16'hD004, 2'b01, 1);
        chk("R5 pass req", dn_req, 1);
        chk("R5 pass data", dn_data, 16'hD004);
        chk("R5 pass ack", up_ack, 1);
        step();
        drive(0, 0, 2'b00, 0);
        chk("R5 merged", merged_o, 1);
    endtask

    task automatic t_merged();
        logic [CW-1:0] c0;
        c0 = load_cnt;
        drive(1, 16'hE005, 2'b00, 0);
        chk("R6 req relay", dn_req, 1);
        chk("R6 data relay", dn_data, 16'hE005);
        chk("R6 ack relay low", up_ack, 0);
        drive(1, 16'hE005, 2'b00, 1);
        chk("R6 ack relay high", up_ack, 1);
        step();
        drive(1, 16'hF006, 2'b01, 1);
        chk("R8 merge on merged passes", dn_data, 16'hF006);
        step();
        drive(1, 16'h1007, 2'b11, 1);
        chk("R8 tag 11 passes", dn_data, 16'h1007);
        step();
        drive(0, 0, 2'b00, 0);
        chk("R8 still merged", merged_o, 1);
        chk("R10 no loads merged", load_cnt, c0);
    endtask

    task automatic t_split();
        logic [CW-1:0] c0;
        c0 = load_cnt;
        drive(1, 16'h2008, 2'b10, 0);
        chk("R7 ack despite stall", up_ack, 1);
        chk("R7 not passed", dn_req, 0);
        step();
        drive(0, 0, 2'b00, 0);
        chk("R7 active again", merged_o, 0);
        chk("R7 presented", dn_data, 16'h2008);
        chk("R7 dn_tag", dn_tag, 2'b10);
        chk("R10 split load", load_cnt, c0 + 1);
        drive(1, 16'h3009, 2'b10, 0);
        chk("R8 split on active waits", up_ack, 0);
        drive(1, 16'h3009, 2'b10, 1);
        step();
        drive(0, 0, 2'b00, 1);
        chk("R8 still active", merged_o, 0);
        chk("R8 captured", dn_data, 16'h3009);
        step();
        drive(0, 0, 2'b00, 0);
    endtask

    task automatic t_stream();
        localparam int N = 40;
        int sent = 0;
        int rcv = 0;
        int bad = 0;
        for (int cyc = 0; cyc < 400 && rcv < N; cyc++) begin
            up_req  = (sent < N);
            up_data = DW'(sent);
            case (sent % 5)
                0: up_tag = 2'b00;
                1: up_tag = 2'b01;
                2: up_tag = 2'b00;
                3: up_tag = 2'b10;
                default: up_tag = 2'b11;
            endcase
            dn_ack = (cyc % 3 != 0);
            #1;
            if (dn_req && dn_ack) begin
                if (dn_data != DW'(rcv)) bad++;
                rcv++;
            end
            if (up_req && up_ack) sent++;
            step();
        end
        drive(0, 0, 2'b00, 0);
        chk("R11 all delivered", rcv, N);
        chk("R11 order kept", bad, 0);
    endtask

    initial begin
        #2_000_000;
        fails++;
        tests++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        rst_n = 1;
        #1;
        t_reset();
        t_active();
        t_merge();
        t_merged();
        t_split();
        t_stream();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule